// File: doc/BRIEF.md
# Twin-Predicated Element Loop Sequencer

This block is a hardware element loop placed between instruction decode and issue. A single scalar template instruction is repeated once per vector element, and the block supplies the element numbers. While the loop runs, the block holds the program counter. The counter is released only once the loop has finished. Source and destination elements are selected independently. Each side has its own predicate mask and its own step counter, so a compress, an expand or a gather-then-scatter pattern comes from one instruction.

For each accepted element pair the block emits two register numbers: each side's base register plus that side's element position, taken modulo the 128-entry register space. Both step counters are architectural state. Software can load them while the block is idle, and the next start then resumes from those positions. This is how an interrupted loop continues after a context switch.

An optional fail-first mode is provided. The condition result of each accepted pair is sampled. The first failing pair cuts the vector length down to that pair's source position, or to one past it, depending on a configuration bit.

Top module: `twin_pred_seq`

## Requirements
- R1: While reset is held, and after it, `pc_hold`, `elem_valid` and `done` are low, and `src_step`, `dst_step` and `vl_out` are zero.
- R2: A `start` pulse seen while idle raises `pc_hold` from the next cycle. `pc_hold` stays high up to and including the cycle in which `done` is high, and is low afterwards. While `pc_hold` is low, `elem_valid` and `done` are low.
- R3: The offered source position is the lowest position at or above `src_step` and below the current length whose bit in the source mask is 1. Mask bit i stands for element i.
- R4: The offered destination position is chosen by the same rule as R3, using the destination mask and `dst_step`, independently of the source side.
- R5: With both masks all ones and `elem_ready` held high, the pairs (0,0), (1,1), … up to length−1 are issued on consecutive cycles.
- R6: `src_reg` equals (`src_base_in` + `src_idx`) mod 128, and `dst_reg` equals (`dst_base_in` + `dst_idx`) mod 128.
- R7: A pair is accepted only in a cycle where `elem_valid` and `elem_ready` are both high. While it waits, the offered pair is held unchanged. On acceptance each step counter becomes its accepted position plus one.
- R8: Values placed on `src_step_in` and `dst_step_in` with `step_ld` while idle appear on `src_step` and `dst_step`, and the next loop starts searching from them. Example: source mask 0b0101 from step 1, destination mask 0b1010 from step 2, length 4, issues only the pair (2,3).
- R9: When either side has no enabled position left below the length, `done` is high for exactly one cycle, both step counters return to 0, and the block goes idle. A length of 0 gives `done` in the first cycle of the loop, with no pair issued.
- R10: With `ffirst_en` = 1 and `ffirst_incl` = 0, accepting a pair with `fail_in` high sets `vl_out` to that pair's source position, and the loop then ends.
- R11: With `ffirst_en` = 1 and `ffirst_incl` = 1, accepting a pair with `fail_in` high sets `vl_out` to its source position plus one, and the loop then ends.
- R12: With `ffirst_en` = 0, `fail_in` has no effect: every pair is issued and `vl_out` keeps the started length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a loop (sampled while idle) |
| vl_in | input | 7 | Vector length for the loop |
| src_mask_in | input | 128 | Source predicate, bit i enables element i |
| dst_mask_in | input | 128 | Destination predicate, bit i enables element i |
| src_base_in | input | 7 | Source base register number |
| dst_base_in | input | 7 | Destination base register number |
| ffirst_en | input | 1 | Enable fail-first truncation |
| ffirst_incl | input | 1 | 1: failing element counts in the new length |
| step_ld | input | 1 | Load saved step state while idle |
| src_step_in | input | 7 | Saved source step |
| dst_step_in | input | 7 | Saved destination step |
| fail_in | input | 1 | Condition test failed for the offered pair |
| elem_ready | input | 1 | Issue stage accepts the offered pair |
| elem_valid | output | 1 | A pair is offered |
| src_idx | output | 7 | Source element position |
| dst_idx | output | 7 | Destination element position |
| src_reg | output | 7 | Source register number |
| dst_reg | output | 7 | Destination register number |
| pc_hold | output | 1 | Program counter held (loop active) |
| done | output | 1 | Single-cycle loop completion |
| vl_out | output | 7 | Current (possibly truncated) length |
| src_step | output | 7 | Source step state |
| dst_step | output | 7 | Destination step state |

## Verification
All-ones masks with a steady ready confirm plain lockstep stepping. Sparse source and dense destination masks with a stalling ready separate the two counters from each other and from the handshake. Base registers near 127 expose wrap-around. The resumed run with complementary masks shows that loaded steps, rather than zero, seed the search. Three runs with the same failure point, using exclude, include and disabled fail-first, tell the three length outcomes apart. A zero-length run isolates immediate termination.

// File: rtl/twin_pred_seq_pkg.sv
// Package: shared types for the twin-predicated element loop sequencer.
// Assumes nothing beyond IEEE 1800-2017 enums.
package twin_pred_seq_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    localparam int SIDE_SRC = 0;
    localparam int SIDE_DST = 1;
    localparam int NUM_SIDES = 2;
endpackage

// File: rtl/elem_pick.sv
// elem_pick: finds the lowest set mask bit whose position lies in
// [from, limit). Assumes mask bit i maps to element i and that limit
// never exceeds the number of mask bits.
module elem_pick #(
    parameter int IDXW = 7
) (
    input  logic [(1<<IDXW)-1:0] mask,
    input  logic [IDXW-1:0]      from,
    input  logic [IDXW-1:0]      limit,
    output logic                 found,
    output logic [IDXW-1:0]      pos
);
    localparam int NELEM = 1 << IDXW;

    // Priority search: scanning downward leaves the lowest hit in pos.
    always_comb begin
        found = 1'b0;
        pos   = '0;
        for (int i = NELEM - 1; i >= 0; i--) begin
            if (mask[i] && (IDXW'(i) >= from) && (IDXW'(i) < limit)) begin
                found = 1'b1;
                pos   = IDXW'(i);
            end
        end
    end
endmodule

// File: rtl/reg_offset.sv
// reg_offset: adds an element position to a base register number,
// wrapping inside the 2**IDXW register space.
module reg_offset #(
    parameter int IDXW = 7
) (
    input  logic [IDXW-1:0] base,
    input  logic [IDXW-1:0] idx,
    output logic [IDXW-1:0] reg_num
);
    // Modulo add: the carry out of the top bit is dropped on purpose.
    assign reg_num = base + idx;
endmodule

// File: rtl/vl_trunc.sv
// vl_trunc: new vector length after a fail-first hit. Assumes pos is at
// most 2**IDXW-2, so adding one never wraps.
module vl_trunc #(
    parameter int IDXW = 7
) (
    input  logic [IDXW-1:0] pos,
    input  logic            incl,
    output logic [IDXW-1:0] vl_new
);
    // Include the failing element by adding one, otherwise stop at it.
    assign vl_new = pos + {{(IDXW-1){1'b0}}, incl};
endmodule

// File: rtl/twin_pred_seq.sv
// twin_pred_seq: element loop sequencer with separate source and
// destination predicates. It holds the program counter while running.
// Each cycle it offers the next enabled pair, advances both steps when
// that pair is accepted, and ends when either side runs out. Assumes a
// start pulse arrives only while pc_hold is low (it is ignored
// otherwise), and that fail_in qualifies the pair currently offered.
module twin_pred_seq
    import twin_pred_seq_pkg::*;
#(
    parameter int IDXW = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [IDXW-1:0]      vl_in,
    input  logic [(1<<IDXW)-1:0] src_mask_in,
    input  logic [(1<<IDXW)-1:0] dst_mask_in,
    input  logic [IDXW-1:0]      src_base_in,
    input  logic [IDXW-1:0]      dst_base_in,
    input  logic                 ffirst_en,
    input  logic                 ffirst_incl,
    input  logic                 step_ld,
    input  logic [IDXW-1:0]      src_step_in,
    input  logic [IDXW-1:0]      dst_step_in,
    input  logic                 fail_in,
    input  logic                 elem_ready,
    output logic                 elem_valid,
    output logic [IDXW-1:0]      src_idx,
    output logic [IDXW-1:0]      dst_idx,
    output logic [IDXW-1:0]      src_reg,
    output logic [IDXW-1:0]      dst_reg,
    output logic                 pc_hold,
    output logic                 done,
    output logic [IDXW-1:0]      vl_out,
    output logic [IDXW-1:0]      src_step,
    output logic [IDXW-1:0]      dst_step
);
    localparam int NELEM = 1 << IDXW;

    seq_state_e                            state_q;
    logic [NUM_SIDES-1:0][NELEM-1:0]       mask_q;
    logic [NUM_SIDES-1:0][IDXW-1:0]        step_q;
    logic [NUM_SIDES-1:0][IDXW-1:0]        base_q;
    logic [NUM_SIDES-1:0][IDXW-1:0]        pos;
    logic [NUM_SIDES-1:0][IDXW-1:0]        regn;
    logic [NUM_SIDES-1:0]                  hit;
    logic [IDXW-1:0]                       vl_q;
    logic [IDXW-1:0]                       vl_cut;
    logic                                  ff_q;
    logic                                  incl_q;
    logic                                  running;
    logic                                  accept;

    // One picker and one offset adder per side; both sides are identical.
    for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
        elem_pick #(.IDXW(IDXW)) u_pick (
            .mask  (mask_q[g]),
            .from  (step_q[g]),
            .limit (vl_q),
            .found (hit[g]),
            .pos   (pos[g])
        );
        reg_offset #(.IDXW(IDXW)) u_off (
            .base    (base_q[g]),
            .idx     (pos[g]),
            .reg_num (regn[g])
        );
    end

    vl_trunc #(.IDXW(IDXW)) u_trunc (
        .pos    (pos[SIDE_SRC]),
        .incl   (incl_q),
        .vl_new (vl_cut)
    );

    // Issue-side decode: offer a pair only when both sides have one.
    always_comb begin
        running    = (state_q == ST_RUN);
        elem_valid = running && (&hit);
        done       = running && !(&hit);
        accept     = elem_valid && elem_ready;
    end

    assign pc_hold  = running;
    assign src_idx  = pos[SIDE_SRC];
    assign dst_idx  = pos[SIDE_DST];
    assign src_reg  = regn[SIDE_SRC];
    assign dst_reg  = regn[SIDE_DST];
    assign vl_out   = vl_q;
    assign src_step = step_q[SIDE_SRC];
    assign dst_step = step_q[SIDE_DST];

    // Loop state: load/start while idle, step or finish while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mask_q  <= '0;
            step_q  <= '0;
            base_q  <= '0;
            vl_q    <= '0;
            ff_q    <= 1'b0;
            incl_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (step_ld) begin
                        step_q[SIDE_SRC] <= src_step_in;
                        step_q[SIDE_DST] <= dst_step_in;
                    end
                    if (start) begin
                        state_q          <= ST_RUN;
                        mask_q[SIDE_SRC] <= src_mask_in;
                        mask_q[SIDE_DST] <= dst_mask_in;
                        base_q[SIDE_SRC] <= src_base_in;
                        base_q[SIDE_DST] <= dst_base_in;
                        vl_q             <= vl_in;
                        ff_q             <= ffirst_en;
                        incl_q           <= ffirst_incl;
                    end
                end
                default: begin
                    if (done) begin
                        state_q <= ST_IDLE;
                        step_q  <= '0;
                    end else if (accept) begin
                        for (int s = 0; s < NUM_SIDES; s++) begin
                            step_q[s] <= pos[s] + 1'b1;
                        end
                        if (ff_q && fail_in) begin
                            vl_q <= vl_cut;
                        end
                    end
                end
            endcase
        end
    end

    // Assertions guarding the loop behaviour.
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_hold |-> (!elem_valid && !done)); // R2
    AST_SRC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        elem_valid |-> (src_idx < vl_out) && mask_q[SIDE_SRC][src_idx]); // R3
    AST_DST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        elem_valid |-> (dst_idx < vl_out) && mask_q[SIDE_DST][dst_idx]); // R4
    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_valid && !elem_ready) |=>
            (elem_valid && $stable(src_idx) && $stable(dst_idx))); // R7
    AST_STEP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (src_step == $past(src_idx) + 1'b1)
                && (dst_step == $past(dst_idx) + 1'b1)); // R7
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !pc_hold && src_step == '0 && dst_step == '0)); // R9
    AST_CUT_EXCLUDE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ff_q && !incl_q && fail_in) |=> (vl_out == $past(src_idx))); // R10
    AST_CUT_INCLUDE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ff_q && incl_q && fail_in) |=> (vl_out == $past(src_idx) + 1'b1)); // R11
    AST_NO_CUT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !ff_q) |=> $stable(vl_out)); // R12
endmodule

// File: tb/twin_pred_seq_tb_top.sv
// Bench: behavioural reference model compared every clock, plus directed
// scenarios that check issued pair sequences against hand-computed lists.
`timescale 1ns/1ps
module twin_pred_seq_tb_top;
    localparam int IDXW  = 7;
    localparam int NELEM = 1 << IDXW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [IDXW-1:0] vl_in = '0;
    logic [NELEM-1:0] src_mask_in = '0;
    logic [NELEM-1:0] dst_mask_in = '0;
    logic [IDXW-1:0] src_base_in = '0;
    logic [IDXW-1:0] dst_base_in = '0;
    logic ffirst_en = 1'b0;
    logic ffirst_incl = 1'b0;
    logic step_ld = 1'b0;
    logic [IDXW-1:0] src_step_in = '0;
    logic [IDXW-1:0] dst_step_in = '0;
    logic fail_in;
    logic elem_ready = 1'b0;
    logic elem_valid, pc_hold, done;
    logic [IDXW-1:0] src_idx, dst_idx, src_reg, dst_reg, vl_out, src_step, dst_step;

    // Fail stimulus: raised for the pair whose source position is fail_at.
    logic fail_arm = 1'b0;
    logic [IDXW-1:0] fail_at = '0;
    assign fail_in = fail_arm && elem_valid && (src_idx == fail_at);

    always #2.5 clk = ~clk;

    twin_pred_seq #(.IDXW(IDXW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in),
        .src_mask_in(src_mask_in), .dst_mask_in(dst_mask_in),
        .src_base_in(src_base_in), .dst_base_in(dst_base_in),
        .ffirst_en(ffirst_en), .ffirst_incl(ffirst_incl),
        .step_ld(step_ld), .src_step_in(src_step_in), .dst_step_in(dst_step_in),
        .fail_in(fail_in), .elem_ready(elem_ready), .elem_valid(elem_valid),
        .src_idx(src_idx), .dst_idx(dst_idx), .src_reg(src_reg), .dst_reg(dst_reg),
        .pc_hold(pc_hold), .done(done), .vl_out(vl_out),
        .src_step(src_step), .dst_step(dst_step)
    );

    int checks = 0;
    int failures = 0;
    bit cmp_en = 1'b0;
    int cycles = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int find_next(input logic [NELEM-1:0] m, input int from, input int lim);
        for (int i = from; i < lim; i++) begin
            if (m[i]) return i;
        end
        return -1;
    endfunction

    // Reference model state
    bit m_run;
    int m_vl, m_ss, m_ds, m_sb, m_db;
    logic [NELEM-1:0] m_sm, m_dm;
    bit m_ff, m_inc;
    int got_s[$];
    int got_d[$];
    int exp_s[$];
    int exp_d[$];

    // Model update and capture of accepted pairs at each rising edge.
    always @(posedge clk) begin
        int es, ed;
        cycles++;
        if (!rst_n) begin
            m_run = 0; m_vl = 0; m_ss = 0; m_ds = 0; m_sb = 0; m_db = 0;
            m_sm = '0; m_dm = '0; m_ff = 0; m_inc = 0;
        end else begin
            if (elem_valid && elem_ready) begin
                got_s.push_back(int'(src_idx));
                got_d.push_back(int'(dst_idx));
            end
            if (!m_run) begin
                if (step_ld) begin
                    m_ss = int'(src_step_in);
                    m_ds = int'(dst_step_in);
                end
                if (start) begin
                    m_run = 1; m_vl = int'(vl_in); m_sm = src_mask_in; m_dm = dst_mask_in;
                    m_sb = int'(src_base_in); m_db = int'(dst_base_in);
                    m_ff = ffirst_en; m_inc = ffirst_incl;
                end
            end else begin
                es = find_next(m_sm, m_ss, m_vl);
                ed = find_next(m_dm, m_ds, m_vl);
                if (es < 0 || ed < 0) begin
                    m_run = 0; m_ss = 0; m_ds = 0;
                end else if (elem_ready) begin
                    m_ss = es + 1;
                    m_ds = ed + 1;
                    if (m_ff && fail_in) m_vl = m_inc ? es + 1 : es;
                end
            end
        end
    end

    // Cycle compare of DUT outputs against the model, away from the edge.
    always @(negedge clk) begin
        int es, ed;
        bit ev;
        if (cmp_en) begin
            es = m_run ? find_next(m_sm, m_ss, m_vl) : -1;
            ed = m_run ? find_next(m_dm, m_ds, m_vl) : -1;
            ev = m_run && es >= 0 && ed >= 0;
            chk(pc_hold == m_run, "R2", "pc_hold", int'(pc_hold), int'(m_run));
            chk(elem_valid == ev, "R3", "elem_valid", int'(elem_valid), int'(ev));
            chk(done == (m_run && !ev), "R9", "done", int'(done), int'(m_run && !ev));
            if (ev && elem_valid) begin
                chk(int'(src_idx) == es, "R3", "src_idx", int'(src_idx), es);
                chk(int'(dst_idx) == ed, "R4", "dst_idx", int'(dst_idx), ed);
                chk(int'(src_reg) == (m_sb + es) % NELEM, "R6", "src_reg",
                    int'(src_reg), (m_sb + es) % NELEM);
                chk(int'(dst_reg) == (m_db + ed) % NELEM, "R6", "dst_reg",
                    int'(dst_reg), (m_db + ed) % NELEM);
            end
            chk(int'(vl_out) == m_vl, "R10", "vl_out", int'(vl_out), m_vl);
            chk(int'(src_step) == m_ss, "R8", "src_step", int'(src_step), m_ss);
            chk(int'(dst_step) == m_ds, "R8", "dst_step", int'(dst_step), m_ds);
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog R9 actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic load_steps(input int s, input int d);
        @(negedge clk); #1;
        step_ld = 1'b1; src_step_in = IDXW'(s); dst_step_in = IDXW'(d);
        @(negedge clk); #1;
        step_ld = 1'b0;
    endtask

    // rdy_mode 0: always ready; 1: ready low one cycle in three.
    task automatic run_loop(input int vl, input logic [NELEM-1:0] sm, input logic [NELEM-1:0] dm,
                            input int sb, input int db, input bit ff, input bit inc,
                            input int rdy_mode);
        bit seen;
        int cyc;
        got_s.delete(); got_d.delete();
        @(negedge clk); #1;
        vl_in = IDXW'(vl); src_mask_in = sm; dst_mask_in = dm;
        src_base_in = IDXW'(sb); dst_base_in = IDXW'(db);
        ffirst_en = ff; ffirst_incl = inc; start = 1'b1;
        elem_ready = 1'b1;
        seen = 0; cyc = 0;
        do begin
            @(negedge clk);
            if (done) seen = 1;
            #1;
            start = 1'b0;
            elem_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
            cyc++;
        end while (!seen && cyc < 2000);
        chk(seen, "R9", "loop finished", int'(seen), 1);
        @(negedge clk); #1;
    endtask

    task automatic check_pairs(input string req);
        chk(got_s.size() == exp_s.size(), req, "pair count", got_s.size(), exp_s.size());
        if (got_s.size() == exp_s.size()) begin
            foreach (exp_s[k]) begin
                chk(got_s[k] == exp_s[k], req, "src position", got_s[k], exp_s[k]);
                chk(got_d[k] == exp_d[k], req, "dst position", got_d[k], exp_d[k]);
            end
        end
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(pc_hold == 1'b0, "R1", "pc_hold", int'(pc_hold), 0);
        chk(elem_valid == 1'b0, "R1", "elem_valid", int'(elem_valid), 0);
        chk(done == 1'b0, "R1", "done", int'(done), 0);
        chk(src_step == '0 && dst_step == '0, "R1", "steps", int'(src_step) + int'(dst_step), 0);
        chk(vl_out == '0, "R1", "vl_out", int'(vl_out), 0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        cmp_en = 1'b1;

        // R5: all-ones lockstep
        run_loop(5, '1, '1, 0, 0, 0, 0, 0);
        exp_s = '{0, 1, 2, 3, 4}; exp_d = '{0, 1, 2, 3, 4};
        check_pairs("R5");
        chk(src_step == '0 && dst_step == '0, "R9", "steps cleared",
            int'(src_step) + int'(dst_step), 0);
        chk(vl_out == 7'd5, "R12", "vl kept", int'(vl_out), 5);

        // R8: resume with complementary masks
        load_steps(1, 2);
        chk(src_step == 7'd1 && dst_step == 7'd2, "R8", "loaded steps",
            int'(src_step) * 10 + int'(dst_step), 12);
        run_loop(4, 128'h5, 128'hA, 0, 0, 0, 0, 0);
        exp_s = '{2}; exp_d = '{3};
        check_pairs("R8");

        // R3/R4/R6/R7: independent sparse masks, wrap, stalling ready
        run_loop(8, 128'h96, 128'h0F, 125, 3, 0, 0, 1);
        exp_s = '{1, 2, 4, 7}; exp_d = '{0, 1, 2, 3};
        check_pairs("R7");

        // R4: destination sparse, source dense; destination runs out first
        run_loop(10, '1, 128'h210, 0, 120, 0, 0, 0);
        exp_s = '{0, 1}; exp_d = '{4, 9};
        check_pairs("R4");

        // R10: fail-first exclude
        fail_arm = 1'b1; fail_at = 7'd3;
        run_loop(8, '1, '1, 0, 0, 1, 0, 0);
        exp_s = '{0, 1, 2, 3}; exp_d = '{0, 1, 2, 3};
        check_pairs("R10");
        chk(vl_out == 7'd3, "R10", "truncated vl", int'(vl_out), 3);

        // R11: fail-first include
        run_loop(8, '1, '1, 0, 0, 1, 1, 0);
        check_pairs("R11");
        chk(vl_out == 7'd4, "R11", "truncated vl", int'(vl_out), 4);

        // R12: fail ignored when fail-first is off
        run_loop(8, '1, '1, 0, 0, 0, 1, 0);
        exp_s = '{0, 1, 2, 3, 4, 5, 6, 7}; exp_d = '{0, 1, 2, 3, 4, 5, 6, 7};
        check_pairs("R12");
        chk(vl_out == 7'd8, "R12", "vl unchanged", int'(vl_out), 8);
        fail_arm = 1'b0;

        // R9: zero length ends at once
        run_loop(0, '1, '1, 0, 0, 0, 0, 0);
        exp_s.delete(); exp_d.delete();
        check_pairs("R9");

        // R5: long lockstep at the top of the range
        run_loop(127, '1, '1, 1, 1, 0, 0, 0);
        chk(got_s.size() == 127, "R5", "long run pairs", got_s.size(), 127);

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule